// File: doc/BRIEF.md
# SD Card Data FIFO with Byte Packing

This block sits between a 32-bit register-side data port and the byte-wide data stream of an SD card. A 16-word circular FIFO holds the words in flight. In the card-to-host direction, bytes arriving from the card are gathered into words, with the first byte in the low bits, and pushed into the FIFO for software to read. In the host-to-card direction, words written by software are taken from the FIFO and sent out one byte at a time, low byte first.

A transfer begins when the block-count value is loaded. The remaining-byte counter is then set to block size times block count, and it drops by one for every byte that moves on the card side. Three sticky status bits record data movement, data interrupts and block-boundary interrupts. A debug word shows the FIFO fill level and a transfer state code.

The card side uses valid/ready handshakes. A byte moves on a clock edge only when valid and ready are both high. The card may hold `card_rx_valid` low, or drive `card_tx_ready` low, for any number of cycles. The block holds `card_rx_ready` low while the FIFO is full, while the counter is zero, or while the register side pushes in the same cycle. The register side has no back-pressure: a push to a full FIFO is lost, and a pop from an empty FIFO returns zero.

Top module: `sd_data_fifo`

## Requirements
- R1: The FIFO holds 16 words and returns them in the order they were pushed. The write slot is (read position + fill level) mod 16. A push while 16 words are held is dropped, and the level stays at 16.
- R2: A pop while the FIFO is empty returns 0 on `host_rdata` in that same cycle, and the level stays at 0.
- R3: One cycle after `blk_count_load` is high, `bytes_left` equals `blk_size` × `blk_count`.
- R4: In read direction, the first card byte of each word lands in bits 7:0, the next in 15:8, and so on. Each accepted byte lowers `bytes_left` by one. A word is pushed when its fourth byte arrives, or as a partial word (upper bytes zero) when `bytes_left` reaches 0. `card_rx_ready` is low while the FIFO is full or `bytes_left` is 0.
- R5: In write direction, each FIFO word is sent as bytes 7:0, 15:8, 23:16, 31:24, in that order. Exactly `bytes_left` bytes are sent. Unsent bytes of the last word are discarded, and `card_tx_valid` is low while `bytes_left` is 0.
- R6: Every word that moves between the FIFO and the packer or unpacker sets `sts_data_flag`. It also sets `sts_data_irq` when `irq_en_data` is high.
- R7: When a card byte leaves `bytes_left` at a nonzero multiple of the block size, `sts_block_irq` is set if `irq_en_block` is high. When `irq_en_block` is low, the bit stays 0.
- R8: `dbg_word[3:0]` is the state code. It is 0 after reset and becomes 1 when a card byte brings `bytes_left` to 0. `dbg_word[8:4]` always shows the FIFO fill level.
- R9: Reset clears the FIFO position and level, `bytes_left`, the status bits and the state code.
- R10: Status bits stay set until cleared through `sts_clear` (bit 0 data flag, bit 1 data irq, bit 2 block irq). A new set wins over a clear in the same cycle. `irq` is high while `sts_data_irq` or `sts_block_irq` is set.
- R11: Read direction wins when `dir_read` and `dir_write` are both high. A register-side push holds `card_rx_ready` low for that cycle. A register-side pop holds off the unpacker's fetch for that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dir_read | input | 1 | Card-to-host direction enable |
| dir_write | input | 1 | Host-to-card direction enable |
| blk_size | input | 10 | Bytes per block |
| blk_count | input | 9 | Number of blocks |
| blk_count_load | input | 1 | Loads the byte counter from size × count |
| irq_en_data | input | 1 | Data interrupt enable |
| irq_en_block | input | 1 | Block interrupt enable |
| sts_clear | input | 3 | Write-one-to-clear of the status bits |
| host_wr | input | 1 | Register-side push strobe |
| host_wdata | input | 32 | Register-side push word |
| host_rd | input | 1 | Register-side pop strobe |
| host_rdata | output | 32 | Word popped (0 if empty) |
| card_rx_valid | input | 1 | Card byte available |
| card_rx_ready | output | 1 | Block accepts a card byte |
| card_rx_data | input | 8 | Card byte |
| card_tx_valid | output | 1 | Byte offered to card |
| card_tx_ready | input | 1 | Card accepts the byte |
| card_tx_data | output | 8 | Byte to card |
| sts_data_flag | output | 1 | Sticky word-moved flag |
| sts_data_irq | output | 1 | Sticky data interrupt |
| sts_block_irq | output | 1 | Sticky block interrupt |
| irq | output | 1 | Interrupt line |
| bytes_left | output | 19 | Remaining byte count |
| dbg_word | output | 9 | {fill level, state code} |

## Verification
The assertions check several rules on every cycle: the fill level never passes 16, an empty pop returns zero, the counter loads to the product and falls by one per card byte, the card is never offered data or accepted data in a way the count and level forbid, and the block interrupt only rises under its enable. The scenarios are needed for the rest. They show byte order inside words, the zero-padded partial last word, bytes discarded at the end of a write, the exact byte on which the block interrupt rises, a FIFO wrap under back-pressure, and the sticky clear behaviour.

// File: rtl/sdf_pkg.sv
package sdf_pkg;
  typedef enum logic [3:0] {
    XST_IDLE = 4'h0,
    XST_DONE = 4'h1
  } xfer_state_e;

  typedef struct packed {
    logic blk_irq;
    logic data_irq;
    logic data_flag;
  } sts_t;
endpackage

// File: rtl/sdf_ring.sv
module sdf_ring #(
  parameter int DEPTH  = 16,
  parameter int WORD_W = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [WORD_W-1:0] push_data,
  input  logic              pop,
  output logic [WORD_W-1:0] pop_data,
  output logic [LVL_W-1:0]  level,
  output logic              full,
  output logic              empty
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0]  rd_pos;
  logic [IDX_W-1:0]  wr_idx;
  logic              do_push, do_pop;

  assign full     = (level == LVL_W'(DEPTH));
  assign empty    = (level == '0);
  assign do_push  = push && !full;
  assign do_pop   = pop && !empty;
  assign wr_idx   = rd_pos + level[IDX_W-1:0];
  assign pop_data = empty ? '0 : mem[rd_pos];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_idx] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_pos <= '0;
      level  <= '0;
    end else begin
      if (do_pop) rd_pos <= rd_pos + 1'b1;
      case ({do_push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/sdf_pack.sv
module sdf_pack #(
  parameter int WORD_W = 32,
  localparam int BPW  = WORD_W / 8,
  localparam int IX_W = $clog2(BPW)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              take,
  input  logic [7:0]        byte_in,
  input  logic              last,
  output logic              push,
  output logic [WORD_W-1:0] word
);
  logic [WORD_W-1:0] acc;
  logic [IX_W-1:0]   idx;
  logic [WORD_W-1:0] placed;

  assign placed = {{(WORD_W-8){1'b0}}, byte_in} << {idx, 3'b000};
  assign word   = acc | placed;
  assign push   = take && ((idx == IX_W'(BPW - 1)) || last);

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      acc <= '0;
      idx <= '0;
    end else if (push) begin
      acc <= '0;
      idx <= '0;
    end else if (take) begin
      acc <= word;
      idx <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/sdf_unpack.sv
module sdf_unpack #(
  parameter int WORD_W = 32,
  localparam int BPW  = WORD_W / 8,
  localparam int NL_W = $clog2(BPW + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              fetch_ok,
  output logic              fetch,
  input  logic [WORD_W-1:0] word_in,
  input  logic              send_en,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              sent
);
  logic [WORD_W-1:0] shreg;
  logic [NL_W-1:0]   nleft;

  assign fetch    = fetch_ok && (nleft == '0);
  assign tx_valid = send_en && (nleft != '0);
  assign sent     = tx_valid && tx_ready;
  assign tx_data  = shreg[7:0];

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      shreg <= '0;
      nleft <= '0;
    end else if (fetch) begin
      shreg <= word_in;
      nleft <= NL_W'(BPW);
    end else if (sent) begin
      shreg <= shreg >> 8;
      nleft <= nleft - 1'b1;
    end
  end
endmodule

// File: rtl/sdf_xfer_ctl.sv
module sdf_xfer_ctl
  import sdf_pkg::*;
#(
  parameter int BSZ_W  = 10,
  parameter int BCNT_W = 9,
  localparam int CNT_W = BSZ_W + BCNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BSZ_W-1:0]  blk_size,
  input  logic [BCNT_W-1:0] blk_count,
  input  logic              step,
  output logic [CNT_W-1:0]  remaining,
  output logic              last,
  output logic              blk_hit,
  output xfer_state_e       state
);
  logic [BSZ_W-1:0] blk_len;
  logic [BSZ_W-1:0] blk_rem;

  assign last    = (remaining == CNT_W'(1));
  assign blk_hit = step && (blk_rem == BSZ_W'(1)) && !last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remaining <= '0;
      blk_len   <= '0;
      blk_rem   <= '0;
      state     <= XST_IDLE;
    end else if (load) begin
      remaining <= CNT_W'(blk_size) * CNT_W'(blk_count);
      blk_len   <= blk_size;
      blk_rem   <= blk_size;
    end else if (step) begin
      remaining <= remaining - 1'b1;
      blk_rem   <= (blk_rem == BSZ_W'(1)) ? blk_len : blk_rem - 1'b1;
      if (last) state <= XST_DONE;
    end
  end
endmodule

// File: rtl/sd_data_fifo.sv
module sd_data_fifo
  import sdf_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int WORD_W     = 32,
  parameter int BSZ_W      = 10,
  parameter int BCNT_W     = 9,
  localparam int CNT_W = BSZ_W + BCNT_W,
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dir_read,
  input  logic              dir_write,
  input  logic [BSZ_W-1:0]  blk_size,
  input  logic [BCNT_W-1:0] blk_count,
  input  logic              blk_count_load,
  input  logic              irq_en_data,
  input  logic              irq_en_block,
  input  logic [2:0]        sts_clear,
  input  logic              host_wr,
  input  logic [WORD_W-1:0] host_wdata,
  input  logic              host_rd,
  output logic [WORD_W-1:0] host_rdata,
  input  logic              card_rx_valid,
  output logic              card_rx_ready,
  input  logic [7:0]        card_rx_data,
  output logic              card_tx_valid,
  input  logic              card_tx_ready,
  output logic [7:0]        card_tx_data,
  output logic              sts_data_flag,
  output logic              sts_data_irq,
  output logic              sts_block_irq,
  output logic              irq,
  output logic [CNT_W-1:0]  bytes_left,
  output logic [LVL_W+3:0]  dbg_word
);
  logic              act_rd, act_wr, cnt_nz, cnt_last, blk_hit;
  logic              rx_take, pk_push, up_fetch, up_fetch_ok, tx_sent, step;
  logic              f_push, f_pop, f_full, f_empty;
  logic [WORD_W-1:0] pk_word, f_push_data, f_pop_data;
  logic [LVL_W-1:0]  f_level;
  xfer_state_e       xstate;
  sts_t              sts, sts_set;

  assign act_rd = dir_read;
  assign act_wr = dir_write && !dir_read;
  assign cnt_nz = (bytes_left != '0);

  assign card_rx_ready = act_rd && cnt_nz && !f_full && !host_wr;
  assign rx_take       = card_rx_valid && card_rx_ready;
  assign up_fetch_ok   = act_wr && cnt_nz && !f_empty && !host_rd;
  assign step          = rx_take || tx_sent;

  assign f_push      = host_wr || pk_push;
  assign f_push_data = pk_push ? pk_word : host_wdata;
  assign f_pop       = host_rd || up_fetch;
  assign host_rdata  = f_pop_data;

  sdf_ring #(.DEPTH(FIFO_DEPTH), .WORD_W(WORD_W)) u_ring (
    .clk(clk), .rst_n(rst_n),
    .push(f_push), .push_data(f_push_data),
    .pop(f_pop), .pop_data(f_pop_data),
    .level(f_level), .full(f_full), .empty(f_empty)
  );

  sdf_pack #(.WORD_W(WORD_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .flush(blk_count_load),
    .take(rx_take), .byte_in(card_rx_data), .last(cnt_last),
    .push(pk_push), .word(pk_word)
  );

  sdf_unpack #(.WORD_W(WORD_W)) u_unpack (
    .clk(clk), .rst_n(rst_n), .flush(blk_count_load),
    .fetch_ok(up_fetch_ok), .fetch(up_fetch), .word_in(f_pop_data),
    .send_en(act_wr && cnt_nz),
    .tx_valid(card_tx_valid), .tx_ready(card_tx_ready),
    .tx_data(card_tx_data), .sent(tx_sent)
  );

  sdf_xfer_ctl #(.BSZ_W(BSZ_W), .BCNT_W(BCNT_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .load(blk_count_load),
    .blk_size(blk_size), .blk_count(blk_count), .step(step),
    .remaining(bytes_left), .last(cnt_last), .blk_hit(blk_hit),
    .state(xstate)
  );

  always_comb begin
    sts_set.data_flag = pk_push || up_fetch;
    sts_set.data_irq  = (pk_push || up_fetch) && irq_en_data;
    sts_set.blk_irq   = blk_hit && irq_en_block;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sts <= '0;
    else        sts <= (sts & ~sts_t'(sts_clear)) | sts_set;
  end

  assign sts_data_flag = sts.data_flag;
  assign sts_data_irq  = sts.data_irq;
  assign sts_block_irq = sts.blk_irq;
  assign irq           = sts.data_irq || sts.blk_irq;
  assign dbg_word      = {f_level, xstate};
endmodule

// File: rtl/sdf_checker.sv
module sdf_checker #(
  parameter int FIFO_DEPTH = 16,
  parameter int WORD_W     = 32,
  parameter int BSZ_W      = 10,
  parameter int BCNT_W     = 9,
  localparam int CNT_W = BSZ_W + BCNT_W,
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [BSZ_W-1:0]  blk_size,
  input logic [BCNT_W-1:0] blk_count,
  input logic              blk_count_load,
  input logic              irq_en_block,
  input logic              host_rd,
  input logic [WORD_W-1:0] host_rdata,
  input logic              card_rx_valid,
  input logic              card_rx_ready,
  input logic              card_tx_valid,
  input logic              card_tx_ready,
  input logic              sts_block_irq,
  input logic [CNT_W-1:0]  bytes_left,
  input logic [LVL_W+3:0]  dbg_word
);
  logic [LVL_W-1:0] lvl;
  logic             byte_moved;
  assign lvl        = dbg_word[LVL_W+3:4];
  assign byte_moved = (card_rx_valid && card_rx_ready) || (card_tx_valid && card_tx_ready);

  assert_level_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    lvl <= LVL_W'(FIFO_DEPTH));

  assert_empty_pop_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && lvl == '0) |-> host_rdata == '0);

  assert_load_product_R3: assert property (@(posedge clk) disable iff (!rst_n)
    blk_count_load |=> bytes_left == CNT_W'($past(blk_size)) * CNT_W'($past(blk_count)));

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl == LVL_W'(FIFO_DEPTH) || bytes_left == '0) |-> !card_rx_ready);

  assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_moved && !blk_count_load) |=> bytes_left == $past(bytes_left) - 1'b1);

  assert_tx_needs_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    card_tx_valid |-> bytes_left != '0);

  assert_blk_irq_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_block_irq) |-> $past(irq_en_block));

  assert_done_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_moved && bytes_left == CNT_W'(1) && !blk_count_load) |=> dbg_word[3:0] == 4'h1);

  assert_one_direction_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(card_rx_ready && card_tx_valid));
endmodule

bind sd_data_fifo sdf_checker #(
  .FIFO_DEPTH(FIFO_DEPTH), .WORD_W(WORD_W), .BSZ_W(BSZ_W), .BCNT_W(BCNT_W)
) u_sdf_checker (
  .clk(clk), .rst_n(rst_n), .blk_size(blk_size), .blk_count(blk_count),
  .blk_count_load(blk_count_load), .irq_en_block(irq_en_block),
  .host_rd(host_rd), .host_rdata(host_rdata),
  .card_rx_valid(card_rx_valid), .card_rx_ready(card_rx_ready),
  .card_tx_valid(card_tx_valid), .card_tx_ready(card_tx_ready),
  .sts_block_irq(sts_block_irq), .bytes_left(bytes_left), .dbg_word(dbg_word)
);

// File: tb/sd_data_fifo_bench.sv
`timescale 1ns/1ps
module sd_data_fifo_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dir_read = 1'b0, dir_write = 1'b0;
  logic [9:0]  blk_size = '0;
  logic [8:0]  blk_count = '0;
  logic        blk_count_load = 1'b0;
  logic        irq_en_data = 1'b0, irq_en_block = 1'b0;
  logic [2:0]  sts_clear = '0;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        card_rx_valid = 1'b0, card_rx_ready;
  logic [7:0]  card_rx_data = '0;
  logic        card_tx_valid, card_tx_ready = 1'b0;
  logic [7:0]  card_tx_data;
  logic        sts_data_flag, sts_data_irq, sts_block_irq, irq;
  logic [18:0] bytes_left;
  logic [8:0]  dbg_word;

  int n_chk = 0, n_fail = 0, tx_seen = 0;
  bit throttle = 1'b0;
  logic [7:0]  exp_tx[$];
  logic [31:0] exp_rd[$];

  sd_data_fifo u_sd_data_fifo (.*);

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // card-side ready pattern for the write direction
  initial forever begin
    @(negedge clk);
    card_tx_ready = throttle ? ($urandom_range(0, 2) != 0) : 1'b1;
  end

  // scoreboard monitor for bytes sent to the card (R5)
  initial forever begin
    @(negedge clk); #1;
    if (card_tx_valid && card_tx_ready) begin
      tx_seen++;
      if (exp_tx.size() == 0) chk(1'b0, "R5 unexpected byte", card_tx_data, 0);
      else begin
        logic [7:0] e;
        e = exp_tx.pop_front();
        chk(card_tx_data == e, "R5 byte order", card_tx_data, e);
      end
    end
  end

  task automatic host_push(input logic [31:0] w);
    @(negedge clk); host_wr = 1'b1; host_wdata = w;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic host_pop_check(input string req);
    logic [31:0] e;
    e = (exp_rd.size() != 0) ? exp_rd.pop_front() : 32'h0;
    @(negedge clk); host_rd = 1'b1; #1;
    chk(host_rdata == e, req, host_rdata, e);
    @(negedge clk); host_rd = 1'b0;
  endtask

  task automatic load(input int bs, input int bc);
    @(negedge clk); blk_size = 10'(bs); blk_count = 9'(bc); blk_count_load = 1'b1;
    @(negedge clk); blk_count_load = 1'b0;
  endtask

  task automatic clear_sts();
    @(negedge clk); sts_clear = 3'b111;
    @(negedge clk); sts_clear = 3'b000;
  endtask

  task automatic card_send(input logic [7:0] b);
    bit r;
    @(negedge clk); card_rx_valid = 1'b1; card_rx_data = b;
    forever begin
      #1 r = card_rx_ready;
      @(posedge clk);
      if (r) break;
      @(negedge clk);
    end
    @(negedge clk); card_rx_valid = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    chk(1'b0, "watchdog", 0, 1);
    report();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R9: reset state
    chk(dbg_word == 9'h0, "R9 dbg after reset", dbg_word, 0);
    chk(bytes_left == 0, "R9 count after reset", bytes_left, 0);
    chk({sts_data_flag, sts_data_irq, sts_block_irq, irq} == 4'b0, "R9 status after reset",
        {sts_data_flag, sts_data_irq, sts_block_irq, irq}, 0);
    chk(!card_rx_ready && !card_tx_valid, "R9 card idle", {card_rx_ready, card_tx_valid}, 0);

    // R2: empty pop
    host_pop_check("R2 empty pop returns zero");
    #1 chk(dbg_word[8:4] == 0, "R2 level stays zero", dbg_word[8:4], 0);

    // R1: fill, overflow drop, ordered drain
    for (int i = 0; i < 17; i++) begin
      host_push(32'hA5000000 + 32'(i));
      if (i < 16) exp_rd.push_back(32'hA5000000 + 32'(i));
    end
    #1 chk(dbg_word[8:4] == 16, "R1 level full after dropped push", dbg_word[8:4], 16);
    for (int i = 0; i < 16; i++) host_pop_check("R1 fifo order");
    #1 chk(dbg_word[8:4] == 0, "R8 level after drain", dbg_word[8:4], 0);

    // Read direction, both dirs set (R11), 5-byte blocks x 2
    clear_sts();
    irq_en_data = 1'b1; irq_en_block = 1'b1;
    dir_read = 1'b1; dir_write = 1'b1;
    load(5, 2);
    #1 chk(bytes_left == 10, "R3 load product", bytes_left, 10);
    @(negedge clk); host_wr = 1'b1; host_wdata = 32'hCAFEF00D; #1;
    chk(!card_rx_ready, "R11 host push stalls card", card_rx_ready, 0);
    exp_rd.push_back(32'hCAFEF00D);
    @(negedge clk); host_wr = 1'b0;
    for (int i = 0; i < 4; i++) card_send(8'h11 + 8'(i));
    #1 chk(dbg_word[8:4] == 2, "R4 full word pushed", dbg_word[8:4], 2);
    chk(sts_data_flag && sts_data_irq, "R6 data flag and irq", {sts_data_flag, sts_data_irq}, 3);
    chk(!sts_block_irq, "R7 no block irq before boundary", sts_block_irq, 0);
    card_send(8'h15);
    #1 chk(sts_block_irq, "R7 block irq at boundary", sts_block_irq, 1);
    chk(bytes_left == 5, "R4 count per byte", bytes_left, 5);
    for (int i = 5; i < 10; i++) card_send(8'h11 + 8'(i));
    #1 chk(bytes_left == 0, "R4 count reaches zero", bytes_left, 0);
    chk(dbg_word[3:0] == 4'h1, "R8 state data mode", dbg_word[3:0], 1);
    chk(dbg_word[8:4] == 4, "R4 partial word pushed", dbg_word[8:4], 4);
    chk(!card_rx_ready, "R4 ready low at zero count", card_rx_ready, 0);
    chk(tx_seen == 0, "R11 read direction wins", tx_seen, 0);
    chk(irq, "R10 irq line", irq, 1);
    exp_rd.push_back(32'h14131211);
    exp_rd.push_back(32'h18171615);
    exp_rd.push_back(32'h00001A19);
    for (int i = 0; i < 4; i++) host_pop_check("R4 packed words");

    // R10: clear one bit only
    @(negedge clk); sts_clear = 3'b100;
    @(negedge clk); sts_clear = 3'b000; #1;
    chk(!sts_block_irq && sts_data_irq, "R10 selective clear", {sts_block_irq, sts_data_irq}, 1);

    // Write direction, irqs disabled, throttled card
    clear_sts();
    irq_en_data = 1'b0; irq_en_block = 1'b0;
    dir_read = 1'b0; dir_write = 1'b1; throttle = 1'b1;
    load(3, 3);
    for (int i = 0; i < 9; i++) exp_tx.push_back(8'h11 * 8'(i + 1));
    host_push(32'h44332211);
    host_push(32'h88776655);
    host_push(32'hCCBBAA99);
    for (int i = 0; i < 400 && bytes_left != 0; i++) @(negedge clk);
    repeat (4) @(negedge clk);
    #1 chk(tx_seen == 9, "R5 exact byte count", tx_seen, 9);
    chk(exp_tx.size() == 0, "R5 all bytes sent", exp_tx.size(), 0);
    chk(!card_tx_valid, "R5 valid low at zero count", card_tx_valid, 0);
    chk(dbg_word[8:4] == 0, "R5 fifo drained", dbg_word[8:4], 0);
    chk(sts_data_flag && !sts_data_irq, "R6 flag without irq", {sts_data_flag, sts_data_irq}, 2);
    chk(!sts_block_irq && !irq, "R7 block irq disabled", {sts_block_irq, irq}, 0);
    @(negedge clk); sts_clear = 3'b001;
    @(negedge clk); sts_clear = 3'b000; #1;
    chk(!sts_data_flag, "R10 flag cleared", sts_data_flag, 0);
    throttle = 1'b0;

    // Read direction with FIFO full back-pressure and index wrap
    dir_write = 1'b0; dir_read = 1'b1;
    load(68, 1);
    for (int i = 0; i < 64; i++) card_send(8'(i));
    #1 chk(dbg_word[8:4] == 16, "R1 level full from card", dbg_word[8:4], 16);
    chk(!card_rx_ready, "R4 ready low when full", card_rx_ready, 0);
    chk(bytes_left == 4, "R4 count held while full", bytes_left, 4);
    host_push(32'hDEADBEEF);
    #1 chk(dbg_word[8:4] == 16, "R1 push to full dropped", dbg_word[8:4], 16);
    for (int k = 0; k < 17; k++)
      exp_rd.push_back({8'(4*k+3), 8'(4*k+2), 8'(4*k+1), 8'(4*k)});
    host_pop_check("R1 wrap order");
    for (int i = 64; i < 68; i++) card_send(8'(i));
    #1 chk(bytes_left == 0, "R4 resumed after pop", bytes_left, 0);
    for (int k = 0; k < 16; k++) host_pop_check("R1 wrap order");
    host_pop_check("R2 empty pop after drain");

    // R9: reset mid-activity
    host_push(32'h1);
    load(4, 4);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1; #1;
    chk(dbg_word == 9'h0, "R9 dbg cleared", dbg_word, 0);
    chk(bytes_left == 0, "R9 count cleared", bytes_left, 0);
    report();
  end
endmodule